// File: doc/BRIEF.md
# Atomic Access Permission Checker

This block rules on whether a conditional-store or exclusive memory access may go ahead. The core's load/store pipe presents the outcome of address translation for the access. This outcome is the fault code, the page's read and write rights and the page's cache attribute. The pipe presents it together with a 6-bit atomic policy register and the virtual address. One cycle later the block returns a response. The response says whether the access must trap, gives the cause code to report, and gives the address to record as the faulting address.

The policy register packs three 2-bit fields, one for each cacheable class of page. The page's cache attribute picks one field. A picked field of zero means atomics are not supported for that class, and the access traps. Pages in isolate mode always trap. When no data cache is built, every page is judged by the bypass field. Attributes outside the four known classes pass unchecked. Only one cause is reported for each request. The order is translation fault first, then the conditional-store permission rule, then the cache-policy rule.

The control is a two-state machine. `S_IDLE` means no response is pending. `S_RESP` means a registered response is on the outputs. The transition `T_ACCEPT` goes from `S_IDLE` to `S_RESP` when `req_valid_i` is high. `T_CHAIN` stays in `S_RESP` when another request arrives at once. `T_DRAIN` goes from `S_RESP` back to `S_IDLE` when no request arrives. `T_WAIT` stays in `S_IDLE` while no request arrives.

Top module: `atom_gate`

## Requirements
- R1: `rsp_valid_o` is high in exactly the cycle after each cycle with `req_valid_i` high and low otherwise; after reset it is low, and `rsp_exc_o` is never high while `rsp_valid_o` is low.
- R2: `rsp_addr_o` carries the `vaddr_i` presented with the request, whether or not the request traps.
- R3: A non-zero `xlat_fault_i` (zero means translation succeeded) makes the response trap with that same code as cause, overriding every other check.
- R4: For a conditional store (`req_excl_i` = 0) with no translation fault, a page that lacks read or write right traps with cause `CAUSE_STORE_DENY` (default 29); exclusive accesses (`req_excl_i` = 1) apply no such rule.
- R5: Cache attribute codes 0 (bypass), 1 (write-through) and 2 (write-back) select policy bits [1:0], [3:2] and [5:4] respectively; a selected field of zero traps, a non-zero one does not, and the other fields have no effect.
- R6: A zero-field trap reports `CAUSE_LDST_ERR` (default 3) for a conditional store and `CAUSE_EXCL_ERR` (default 23) for an exclusive access.
- R7: Attribute code 3 (isolate) traps with `CAUSE_LDST_ERR` for both access types, whatever the policy register holds.
- R8: With `dcache_present_i` low, the bypass field [1:0] decides for every attribute code, including isolate and codes 4 to 7.
- R9: With `dcache_present_i` high, attribute codes 4 to 7 never trap on policy grounds, even with the policy register all zero.
- R10: A response without a trap shows `rsp_exc_o` = 0 and `rsp_cause_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request strobe, one cycle per request |
| req_excl_i | input | 1 | 1 = exclusive access, 0 = conditional store |
| req_write_i | input | 1 | Write flag of the access (carried to translation; no effect here) |
| xlat_fault_i | input | 6 | Translation cause code, 0 = no fault |
| page_rd_i | input | 1 | Page is readable |
| page_wr_i | input | 1 | Page is writable |
| cache_attr_i | input | 3 | Page cache attribute code |
| dcache_present_i | input | 1 | Data cache is configured |
| policy_i | input | 6 | Atomic policy register, three 2-bit fields |
| vaddr_i | input | 32 | Virtual address of the access |
| rsp_valid_o | output | 1 | Response valid |
| rsp_exc_o | output | 1 | Access must trap |
| rsp_cause_o | output | 6 | Cause code of the trap |
| rsp_addr_o | output | 32 | Faulting virtual address |

## Verification
The priority chain is where functions collide. In one request a translation fault can coincide with an isolate page or a zero policy field. A conditional store can also meet a page without write right and a zero policy field at the same time. The bench builds such requests on purpose. It expects the higher-ranked cause alone: the translation code over everything, and store-deny over the policy causes. A second collision is the pipeline handoff, where a new request arrives in the same cycle a response is shown. The bench issues two requests back to back and checks that each response keeps its own cause and address.

// File: rtl/atom_gate_pkg.sv
package atom_gate_pkg;

    localparam int ATTR_W = 3;

    localparam logic [ATTR_W-1:0] ATTR_BYPASS = 3'd0;
    localparam logic [ATTR_W-1:0] ATTR_WTHRU  = 3'd1;
    localparam logic [ATTR_W-1:0] ATTR_WBACK  = 3'd2;
    localparam logic [ATTR_W-1:0] ATTR_ISOL   = 3'd3;

    // Which kind of cache-policy verdict applies to an access.
    typedef enum logic [1:0] {
        POL_NONE  = 2'd0,
        POL_FIELD = 2'd1,
        POL_ISOL  = 2'd2
    } pol_class_e;

    typedef enum logic {
        S_IDLE = 1'b0,
        S_RESP = 1'b1
    } gate_state_e;

endpackage

// File: rtl/atom_attr_map.sv
module atom_attr_map
    import atom_gate_pkg::*;
#(
    parameter int FIELD_W    = 2,
    parameter int NUM_FIELDS = 3
) (
    input  logic [ATTR_W-1:0]             attr_i,
    input  logic                          dc_present_i,
    input  logic [FIELD_W*NUM_FIELDS-1:0] policy_i,
    output pol_class_e                    class_o,
    output logic                          field_zero_o
);

    logic [NUM_FIELDS-1:0] zero_vec;
    logic [ATTR_W-1:0]     eff_attr;

    // One zero detector per policy field.
    for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_field
        assign zero_vec[g] = (policy_i[g*FIELD_W +: FIELD_W] == '0);
    end

    always_comb begin
        // Without a data cache every page is judged as bypass.
        eff_attr     = dc_present_i ? attr_i : ATTR_BYPASS;
        class_o      = POL_NONE;
        field_zero_o = 1'b0;
        for (int k = 0; k < NUM_FIELDS; k++) begin
            if (eff_attr == ATTR_W'(k)) begin
                class_o      = POL_FIELD;
                field_zero_o = zero_vec[k];
            end
        end
        if (eff_attr == ATTR_ISOL) begin
            class_o = POL_ISOL;
        end
    end

endmodule

// File: rtl/atom_prio.sv
module atom_prio
    import atom_gate_pkg::*;
#(
    parameter int                 CAUSE_W          = 6,
    parameter logic [CAUSE_W-1:0] CAUSE_STORE_DENY = 6'd29,
    parameter logic [CAUSE_W-1:0] CAUSE_LDST_ERR   = 6'd3,
    parameter logic [CAUSE_W-1:0] CAUSE_EXCL_ERR   = 6'd23
) (
    input  logic [CAUSE_W-1:0] fault_i,
    input  logic               is_excl_i,
    input  logic               page_rd_i,
    input  logic               page_wr_i,
    input  pol_class_e         class_i,
    input  logic               field_zero_i,
    output logic               exc_o,
    output logic [CAUSE_W-1:0] cause_o
);

    logic perm_deny;

    // A conditional store needs both rights; only the store cause is used.
    assign perm_deny = !is_excl_i && !(page_rd_i && page_wr_i);

    always_comb begin
        exc_o   = 1'b0;
        cause_o = '0;
        if (fault_i != '0) begin
            exc_o   = 1'b1;
            cause_o = fault_i;
        end else if (perm_deny) begin
            exc_o   = 1'b1;
            cause_o = CAUSE_STORE_DENY;
        end else begin
            unique case (class_i)
                POL_ISOL: begin
                    exc_o   = 1'b1;
                    cause_o = CAUSE_LDST_ERR;
                end
                POL_FIELD: begin
                    if (field_zero_i) begin
                        exc_o   = 1'b1;
                        cause_o = is_excl_i ? CAUSE_EXCL_ERR : CAUSE_LDST_ERR;
                    end
                end
                default: begin
                    exc_o   = 1'b0;
                    cause_o = '0;
                end
            endcase
        end
    end

endmodule

// File: rtl/atom_gate.sv
module atom_gate
    import atom_gate_pkg::*;
#(
    parameter int                 ADDR_W           = 32,
    parameter int                 CAUSE_W          = 6,
    parameter int                 FIELD_W          = 2,
    parameter int                 NUM_FIELDS       = 3,
    parameter logic [CAUSE_W-1:0] CAUSE_STORE_DENY = 6'd29,
    parameter logic [CAUSE_W-1:0] CAUSE_LDST_ERR   = 6'd3,
    parameter logic [CAUSE_W-1:0] CAUSE_EXCL_ERR   = 6'd23
) (
    input  logic                          clk_i,
    input  logic                          rst_ni,
    input  logic                          req_valid_i,
    input  logic                          req_excl_i,
    input  logic                          req_write_i,
    input  logic [CAUSE_W-1:0]            xlat_fault_i,
    input  logic                          page_rd_i,
    input  logic                          page_wr_i,
    input  logic [ATTR_W-1:0]             cache_attr_i,
    input  logic                          dcache_present_i,
    input  logic [FIELD_W*NUM_FIELDS-1:0] policy_i,
    input  logic [ADDR_W-1:0]             vaddr_i,
    output logic                          rsp_valid_o,
    output logic                          rsp_exc_o,
    output logic [CAUSE_W-1:0]            rsp_cause_o,
    output logic [ADDR_W-1:0]             rsp_addr_o
);

    pol_class_e         pol_class;
    logic               field_zero;
    logic               exc_d;
    logic [CAUSE_W-1:0] cause_d;
    logic               unused_write;

    gate_state_e        state_q, state_d;
    logic               exc_q;
    logic [CAUSE_W-1:0] cause_q;
    logic [ADDR_W-1:0]  addr_q;

    // The write flag only steers translation, which lies upstream.
    assign unused_write = req_write_i;

    atom_attr_map #(
        .FIELD_W    (FIELD_W),
        .NUM_FIELDS (NUM_FIELDS)
    ) u_map (
        .attr_i       (cache_attr_i),
        .dc_present_i (dcache_present_i),
        .policy_i     (policy_i),
        .class_o      (pol_class),
        .field_zero_o (field_zero)
    );

    atom_prio #(
        .CAUSE_W          (CAUSE_W),
        .CAUSE_STORE_DENY (CAUSE_STORE_DENY),
        .CAUSE_LDST_ERR   (CAUSE_LDST_ERR),
        .CAUSE_EXCL_ERR   (CAUSE_EXCL_ERR)
    ) u_prio (
        .fault_i      (xlat_fault_i),
        .is_excl_i    (req_excl_i),
        .page_rd_i    (page_rd_i),
        .page_wr_i    (page_wr_i),
        .class_i      (pol_class),
        .field_zero_i (field_zero),
        .exc_o        (exc_d),
        .cause_o      (cause_d)
    );

    // Next-state logic: T_ACCEPT, T_CHAIN, T_DRAIN, T_WAIT.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  state_d = req_valid_i ? S_RESP : S_IDLE;
            S_RESP:  state_d = req_valid_i ? S_RESP : S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Output register: captures the verdict on each accepted request.
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            exc_q   <= 1'b0;
            cause_q <= '0;
            addr_q  <= '0;
        end else if (req_valid_i) begin
            exc_q   <= exc_d;
            cause_q <= cause_d;
            addr_q  <= vaddr_i;
        end else begin
            exc_q   <= 1'b0;
        end
    end

    assign rsp_valid_o = (state_q == S_RESP);
    assign rsp_exc_o   = exc_q;
    assign rsp_cause_o = cause_q;
    assign rsp_addr_o  = addr_q;

    // ---------------- assertions ----------------
    assert_rsp_follows_req_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        req_valid_i |=> rsp_valid_o);

    assert_rsp_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !req_valid_i |=> !rsp_valid_o);

    assert_exc_needs_valid_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rsp_valid_o |-> !rsp_exc_o);

    assert_addr_capture_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        req_valid_i |=> (rsp_addr_o == $past(vaddr_i)));

    assert_xlat_first_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_valid_i && xlat_fault_i != '0) |=> (rsp_exc_o && rsp_cause_o == $past(xlat_fault_i)));

    assert_store_deny_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_valid_i && xlat_fault_i == '0 && !req_excl_i && !(page_rd_i && page_wr_i))
        |=> (rsp_exc_o && rsp_cause_o == CAUSE_STORE_DENY));

    assert_isolate_trap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_valid_i && xlat_fault_i == '0 && dcache_present_i && cache_attr_i == ATTR_ISOL
         && (req_excl_i || (page_rd_i && page_wr_i)))
        |=> (rsp_exc_o && rsp_cause_o == CAUSE_LDST_ERR));

    assert_other_pass_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_valid_i && xlat_fault_i == '0 && dcache_present_i && cache_attr_i[2]
         && (req_excl_i || (page_rd_i && page_wr_i)))
        |=> !rsp_exc_o);

    assert_clean_zero_cause_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rsp_valid_o && !rsp_exc_o) |-> (rsp_cause_o == '0));

endmodule

// File: tb/atom_gate_tb_top.sv
`timescale 1ns/1ps
module atom_gate_tb_top;

    localparam logic [5:0] C_DENY = 6'd29;
    localparam logic [5:0] C_LDST = 6'd3;
    localparam logic [5:0] C_EXCL = 6'd23;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_excl = 1'b0;
    logic        req_write = 1'b0;
    logic [5:0]  xlat_fault = '0;
    logic        page_rd = 1'b0;
    logic        page_wr = 1'b0;
    logic [2:0]  cache_attr = '0;
    logic        dc_present = 1'b0;
    logic [5:0]  policy = '0;
    logic [31:0] vaddr = '0;
    logic        rsp_valid;
    logic        rsp_exc;
    logic [5:0]  rsp_cause;
    logic [31:0] rsp_addr;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    atom_gate dut_i (
        .clk_i            (clk),
        .rst_ni           (rst_n),
        .req_valid_i      (req_valid),
        .req_excl_i       (req_excl),
        .req_write_i      (req_write),
        .xlat_fault_i     (xlat_fault),
        .page_rd_i        (page_rd),
        .page_wr_i        (page_wr),
        .cache_attr_i     (cache_attr),
        .dcache_present_i (dc_present),
        .policy_i         (policy),
        .vaddr_i          (vaddr),
        .rsp_valid_o      (rsp_valid),
        .rsp_exc_o        (rsp_exc),
        .rsp_cause_o      (rsp_cause),
        .rsp_addr_o       (rsp_addr)
    );

    task automatic drive(input bit excl, input bit wr, input logic [5:0] flt,
                         input bit rd, input bit wp, input logic [2:0] attr,
                         input bit dc, input logic [5:0] pol, input logic [31:0] va);
        req_valid  = 1'b1;
        req_excl   = excl;
        req_write  = wr;
        xlat_fault = flt;
        page_rd    = rd;
        page_wr    = wp;
        cache_attr = attr;
        dc_present = dc;
        policy     = pol;
        vaddr      = va;
    endtask

    task automatic expect_rsp(input bit e_exc, input logic [5:0] e_cause,
                              input logic [31:0] e_addr, input string tag);
        checks++;
        if (rsp_valid !== 1'b1 || rsp_exc !== e_exc || rsp_cause !== e_cause || rsp_addr !== e_addr) begin
            errors++;
            $display("FAIL %s: got v=%b exc=%b cause=%0d addr=%h, want v=1 exc=%b cause=%0d addr=%h",
                     tag, rsp_valid, rsp_exc, rsp_cause, rsp_addr, e_exc, e_cause, e_addr);
        end
    endtask

    task automatic run_one(input bit excl, input logic [5:0] flt, input bit rd, input bit wp,
                           input logic [2:0] attr, input bit dc, input logic [5:0] pol,
                           input logic [31:0] va, input bit e_exc, input logic [5:0] e_cause,
                           input string tag);
        drive(excl, 1'b1, flt, rd, wp, attr, dc, pol, va);
        @(negedge clk);
        expect_rsp(e_exc, e_cause, va, tag);
        req_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset;
        checks++;
        if (rsp_valid !== 1'b0 || rsp_exc !== 1'b0) begin
            errors++;
            $display("FAIL R1 reset: got v=%b exc=%b, want 0 0", rsp_valid, rsp_exc);
        end
    endtask

    task automatic t_clean;
        run_one(1'b0, 6'd0, 1, 1, 3'd0, 1, 6'b01_01_01, 32'h1000_0040, 1'b0, 6'd0, "R10 R2 clean store");
        run_one(1'b1, 6'd0, 1, 1, 3'd2, 1, 6'b11_00_00, 32'hCAFE_0010, 1'b0, 6'd0, "R10 R2 clean excl");
    endtask

    task automatic t_xlat;
        run_one(1'b0, 6'd12, 0, 0, 3'd3, 1, 6'd0, 32'h0000_0100, 1'b1, 6'd12, "R3 fault over isolate");
        run_one(1'b1, 6'd26, 1, 1, 3'd1, 1, 6'd0, 32'h0000_0200, 1'b1, 6'd26, "R3 fault over policy");
    endtask

    task automatic t_perm;
        run_one(1'b0, 6'd0, 1, 0, 3'd0, 1, 6'd0, 32'h0000_0300, 1'b1, C_DENY, "R4 store read-only");
        run_one(1'b0, 6'd0, 0, 1, 3'd3, 1, 6'd0, 32'h0000_0304, 1'b1, C_DENY, "R4 store write-only over isolate");
        run_one(1'b1, 6'd0, 1, 0, 3'd0, 1, 6'b00_00_01, 32'h0000_0308, 1'b0, 6'd0, "R4 excl ignores rights");
    endtask

    task automatic t_policy;
        run_one(1'b0, 6'd0, 1, 1, 3'd1, 1, 6'b11_00_11, 32'h0000_0400, 1'b1, C_LDST, "R5 R6 WT zero store");
        run_one(1'b1, 6'd0, 1, 1, 3'd2, 1, 6'b00_11_11, 32'h0000_0404, 1'b1, C_EXCL, "R5 R6 WB zero excl");
        run_one(1'b1, 6'd0, 1, 1, 3'd0, 1, 6'b11_11_00, 32'h0000_0408, 1'b1, C_EXCL, "R5 R6 bypass zero excl");
        run_one(1'b0, 6'd0, 1, 1, 3'd2, 1, 6'b10_00_00, 32'h0000_040C, 1'b0, 6'd0, "R5 WB nonzero others zero");
    endtask

    task automatic t_isol;
        run_one(1'b0, 6'd0, 1, 1, 3'd3, 1, 6'b11_11_11, 32'h0000_0500, 1'b1, C_LDST, "R7 isolate store");
        run_one(1'b1, 6'd0, 0, 0, 3'd3, 1, 6'b11_11_11, 32'h0000_0504, 1'b1, C_LDST, "R7 isolate excl");
    endtask

    task automatic t_nodc;
        run_one(1'b0, 6'd0, 1, 1, 3'd2, 0, 6'b11_11_00, 32'h0000_0600, 1'b1, C_LDST, "R8 no cache uses bypass");
        run_one(1'b1, 6'd0, 1, 1, 3'd3, 0, 6'b00_00_01, 32'h0000_0604, 1'b0, 6'd0, "R8 no cache isolate passes");
        run_one(1'b1, 6'd0, 1, 1, 3'd6, 0, 6'b11_11_00, 32'h0000_0608, 1'b1, C_EXCL, "R8 no cache code 6");
    endtask

    task automatic t_other;
        run_one(1'b0, 6'd0, 1, 1, 3'd4, 1, 6'd0, 32'h0000_0700, 1'b0, 6'd0, "R9 code 4 passes");
        run_one(1'b1, 6'd0, 1, 1, 3'd7, 1, 6'd0, 32'h0000_0704, 1'b0, 6'd0, "R9 code 7 passes");
    endtask

    task automatic t_b2b;
        drive(1'b0, 1'b1, 6'd0, 1, 0, 3'd0, 1, 6'd1, 32'hAAAA_0000);
        @(negedge clk);
        expect_rsp(1'b1, C_DENY, 32'hAAAA_0000, "R1 R2 back-to-back first");
        drive(1'b1, 1'b0, 6'd0, 1, 1, 3'd1, 1, 6'b11_01_11, 32'hBBBB_0004);
        @(negedge clk);
        expect_rsp(1'b0, 6'd0, 32'hBBBB_0004, "R1 R2 back-to-back second");
        req_valid = 1'b0;
        @(negedge clk);
        checks++;
        if (rsp_valid !== 1'b0 || rsp_exc !== 1'b0) begin
            errors++;
            $display("FAIL R1 drain: got v=%b exc=%b, want 0 0", rsp_valid, rsp_exc);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_clean();
        t_xlat();
        t_perm();
        t_policy();
        t_isol();
        t_nodc();
        t_other();
        t_b2b();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout, want completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule